// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block fills a destination vector from scattered memory locations, one element at a time. Each element's address is formed from a 64-bit base, a signed 32-bit per-lane index and a power-of-two scale. The block reads only the lanes enabled in a write mask and merges the returned data into a copy of the old destination. Lanes that are not enabled keep their old contents. Elements are either 32 bits wide (16 lanes) or 64 bits wide (8 lanes). The index vector always carries 16 dword lanes, and only the lower 8 are used in the 64-bit mode.

Progress is recorded in the mask itself. A lane's mask bit is cleared once its data has been written. If a read comes back faulting, the sequencer stops and reports the lane position. The updated destination and mask then describe a partial state that can be resubmitted to resume the work. Reads go out in ascending lane order, and only one read is outstanding at a time. A given input set and fault pattern therefore always leaves the same lanes complete.

The controller is a five-state machine: `ST_IDLE`, `ST_PICK`, `ST_ISSUE`, `ST_WAIT` and `ST_STOP`. Its transitions are:

- LAUNCH: `ST_IDLE`→`ST_PICK` on `start`.
- NEXT: `ST_PICK`→`ST_ISSUE` when an enabled lane remains.
- DRAINED: `ST_PICK`→`ST_STOP` when no enabled lane remains.
- SENT: `ST_ISSUE`→`ST_WAIT`, always.
- RETIRE: `ST_WAIT`→`ST_PICK` on a clean response.
- ABORT: `ST_WAIT`→`ST_STOP` on a faulting response.
- CLOSE: `ST_STOP`→`ST_IDLE`, always.

Top module: `vgather_seq`

## Requirements
- R1: With `wide`=0 there are 16 elements of 32 bits, and element i sits at `dest_out[32i+31:32i]`. With `wide`=1 there are 8 elements of 64 bits, element i sits at `dest_out[64i+63:64i]`, and mask bits 15..8 are cleared when the gather is launched.
- R2: Element i is read at address `base + (sign_extend(idx_vec[32i+31:32i]) << scale_sh)`, computed modulo 2^64. A `scale_sh` of 0, 1, 2 or 3 means a scale of 1, 2, 4 or 8.
- R3: Only lanes whose `mask_in` bit is 1 are read. Every other destination element keeps its `dest_in` value.
- R4: When every enabled lane returns without fault, `mask_out` is all zero, `flt` is 0 and `done` is raised.
- R5: Reads are issued one at a time in ascending lane order. `mem_req` is a one-cycle pulse, and no new request is issued until `mem_rsp` for the previous one has been received.
- R6: On a faulting response, all enabled lanes below the faulting one are already written and their mask bits are cleared. The faulting lane and the enabled lanes above it keep their mask bits, and those lanes keep their old destination values. `flt` goes to 1 and `flt_lane` shows the position; both hold until the next accepted `start`.
- R7: In the 64-bit mode, mask bits 15..8 read zero even when the very first read faults.
- R8: Addresses are never checked for alignment. A misaligned address completes normally.
- R9: `start` and the other launch inputs are ignored while `busy` is 1.
- R10: `busy` is 1 from the cycle after an accepted `start` until the gather ends. `done` is a single-cycle pulse at the end of every gather, whether it completed or faulted.
- R11: After reset the block is idle, with `busy`, `done`, `flt` and `mem_req` at 0 and `dest_out` and `mask_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a gather (accepted only when idle) |
| wide | input | 1 | 1 selects 64-bit elements, 0 selects 32-bit elements |
| scale_sh | input | 2 | Scale as a left-shift amount |
| base | input | 64 | Base address |
| idx_vec | input | 512 | Sixteen signed 32-bit indices |
| mask_in | input | 16 | Lane enable mask |
| dest_in | input | 512 | Old destination vector |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle end-of-gather pulse |
| dest_out | output | 512 | Merged destination vector |
| mask_out | output | 16 | Remaining mask (lanes not yet gathered) |
| flt | output | 1 | The last gather stopped on a fault |
| flt_lane | output | 4 | Position of the faulting lane |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read address |
| mem_rsp | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read data (low 32 bits used in the 32-bit mode) |
| mem_fault | input | 1 | The response faulted |

## Verification
A stale or misdirected lane register would show up at the memory port at once. The next request would carry an address that does not match the lowest lane still pending, so the responder catches it on the very first wrong read. A corrupted mask register shows up later: either a lane is skipped or repeated in the request stream, or the final `mask_out` and `dest_out` disagree with the partial state the fault position implies. That mismatch is visible on the `done` cycle. A state machine that drops or doubles its end pulse breaks the one-cycle `done` check in the cycle that follows.

// File: rtl/vg_pkg.sv
`timescale 1ns/1ps
package vg_pkg;

    // Controller states of the gather sequencer.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PICK  = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_STOP  = 3'd4
    } vg_state_e;

endpackage

// File: rtl/vg_lane_pick.sv
`timescale 1ns/1ps
// Finds the lowest-numbered pending lane (priority toward lane 0).
module vg_lane_pick #(
    parameter int LANES = 16,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic             any,
    output logic [LW-1:0]    lane
);

    always_comb begin
        any  = |pend;
        lane = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                lane = LW'(i);
            end
        end
    end

endmodule

// File: rtl/vg_addr_gen.sv
`timescale 1ns/1ps
// Element address: base + sign-extended index shifted by the scale code.
module vg_addr_gen #(
    parameter int LANES  = 16,
    parameter int IDX_W  = 32,
    parameter int ADDR_W = 64,
    parameter int LW     = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0]      base,
    input  logic [LANES*IDX_W-1:0] idx_vec,
    input  logic [LW-1:0]          lane,
    input  logic [1:0]             scale_sh,
    output logic [ADDR_W-1:0]      addr
);

    localparam int EXT_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  idx_sel;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        idx_sel = idx_vec[lane*IDX_W +: IDX_W];
        offset  = {{EXT_W{idx_sel[IDX_W-1]}}, idx_sel};
        addr    = base + (offset << scale_sh);
    end

endmodule

// File: rtl/vg_dest_merge.sv
`timescale 1ns/1ps
// Destination register: loaded whole at launch, then one element per retire.
module vg_dest_merge #(
    parameter int LANES  = 16,
    parameter int SLOT_W = 32,
    parameter int LW     = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LANES*SLOT_W-1:0] load_val,
    input  logic                    wr_en,
    input  logic                    wide,
    input  logic [LW-1:0]           lane,
    input  logic [2*SLOT_W-1:0]     wr_data,
    output logic [LANES*SLOT_W-1:0] dest
);

    for (genvar s = 0; s < LANES; s++) begin : g_slot
        localparam bit ODD = (s % 2) == 1;

        logic [SLOT_W-1:0] slot_q;
        logic              hit_narrow;
        logic              hit_wide;

        assign hit_narrow = !wide && (lane == LW'(s));
        assign hit_wide   = wide && (lane == LW'(s / 2));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (load) begin
                slot_q <= load_val[s*SLOT_W +: SLOT_W];
            end else if (wr_en && hit_narrow) begin
                slot_q <= wr_data[SLOT_W-1:0];
            end else if (wr_en && hit_wide) begin
                slot_q <= ODD ? wr_data[2*SLOT_W-1:SLOT_W] : wr_data[SLOT_W-1:0];
            end
        end

        assign dest[s*SLOT_W +: SLOT_W] = slot_q;
    end

endmodule

// File: rtl/vgather_seq.sv
`timescale 1ns/1ps
// Masked gather sequencer: one outstanding read, ascending lane order,
// progress kept in the mask so a fault leaves a resumable state.
module vgather_seq #(
    parameter int LANES  = 16,
    parameter int IDX_W  = 32,
    parameter int SLOT_W = 32,
    parameter int ADDR_W = 64,
    localparam int LW     = $clog2(LANES),
    localparam int WORD_W = 2 * SLOT_W,
    localparam int VEC_W  = LANES * SLOT_W,
    localparam int IDXV_W = LANES * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [1:0]        scale_sh,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDXV_W-1:0] idx_vec,
    input  logic [LANES-1:0]  mask_in,
    input  logic [VEC_W-1:0]  dest_in,
    output logic              busy,
    output logic              done,
    output logic [VEC_W-1:0]  dest_out,
    output logic [LANES-1:0]  mask_out,
    output logic              flt,
    output logic [LW-1:0]     flt_lane,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_fault
);
    import vg_pkg::*;

    localparam int HALF = LANES / 2;
    localparam logic [LANES-1:0] LOW_HALF = {{(LANES - HALF){1'b0}}, {HALF{1'b1}}};

    vg_state_e state_q, state_d;

    logic              wide_q;
    logic [1:0]        scale_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDXV_W-1:0] idx_q;
    logic [LANES-1:0]  mask_q;
    logic [LW-1:0]     lane_q;
    logic              flt_q;
    logic [LW-1:0]     flt_lane_q;

    logic              pick_any;
    logic [LW-1:0]     pick_lane;
    logic              launch;
    logic              retire;
    logic              abort;

    assign launch = (state_q == ST_IDLE) && start;
    assign retire = (state_q == ST_WAIT) && mem_rsp && !mem_fault;
    assign abort  = (state_q == ST_WAIT) && mem_rsp && mem_fault;

    vg_lane_pick #(
        .LANES (LANES),
        .LW    (LW)
    ) u_pick (
        .pend (mask_q),
        .any  (pick_any),
        .lane (pick_lane)
    );

    vg_addr_gen #(
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .LW     (LW)
    ) u_addr (
        .base     (base_q),
        .idx_vec  (idx_q),
        .lane     (lane_q),
        .scale_sh (scale_q),
        .addr     (mem_addr)
    );

    vg_dest_merge #(
        .LANES  (LANES),
        .SLOT_W (SLOT_W),
        .LW     (LW)
    ) u_dest (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (dest_in),
        .wr_en    (retire),
        .wide     (wide_q),
        .lane     (lane_q),
        .wr_data  (mem_rdata),
        .dest     (dest_out)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_PICK;                 // LAUNCH
            ST_PICK:  state_d = pick_any ? ST_ISSUE : ST_STOP;      // NEXT / DRAINED
            ST_ISSUE: state_d = ST_WAIT;                            // SENT
            ST_WAIT: begin
                if (mem_rsp) begin
                    state_d = mem_fault ? ST_STOP : ST_PICK;        // ABORT / RETIRE
                end
            end
            ST_STOP:  state_d = ST_IDLE;                            // CLOSE
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // State-decoded outputs.
    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        mem_req = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy    = 1'b0;
            ST_PICK:  ;
            ST_ISSUE: mem_req = 1'b1;
            ST_WAIT:  ;
            ST_STOP:  done    = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

    // Operand, mask and fault registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q     <= 1'b0;
            scale_q    <= '0;
            base_q     <= '0;
            idx_q      <= '0;
            mask_q     <= '0;
            lane_q     <= '0;
            flt_q      <= 1'b0;
            flt_lane_q <= '0;
        end else begin
            if (launch) begin
                wide_q     <= wide;
                scale_q    <= scale_sh;
                base_q     <= base;
                idx_q      <= idx_vec;
                mask_q     <= wide ? (mask_in & LOW_HALF) : mask_in;
                flt_q      <= 1'b0;
                flt_lane_q <= '0;
            end
            if ((state_q == ST_PICK) && pick_any) begin
                lane_q <= pick_lane;
            end
            if (retire) begin
                mask_q[lane_q] <= 1'b0;
            end
            if (abort) begin
                flt_q      <= 1'b1;
                flt_lane_q <= lane_q;
            end
        end
    end

    assign mask_out = mask_q;
    assign flt      = flt_q;
    assign flt_lane = flt_lane_q;

endmodule

// File: rtl/vgather_seq_chk.sv
`timescale 1ns/1ps
// Temporal checks on the gather sequencer.
module vgather_seq_chk #(
    parameter int LANES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             flt,
    input logic             mem_req,
    input logic             wide_q,
    input logic [LANES-1:0] mask_out
);
    localparam int HALF = LANES / 2;

    // R5: a request never lasts more than one cycle
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R5: no request while idle
    p_req_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a clean finish leaves the mask empty
    p_clean_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flt) |-> (mask_out == '0));

    // R7: upper mask half stays clear in the 64-bit mode
    p_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wide_q) |-> (mask_out[LANES-1:HALF] == '0));

    // R6: during a gather mask bits are only ever cleared
    p_mask_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((mask_out & ~$past(mask_out)) == '0));

    // R6: the fault flag rises only together with the end pulse
    p_fault_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt) |-> done);

endmodule

bind vgather_seq vgather_seq_chk #(
    .LANES (LANES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .flt      (flt),
    .mem_req  (mem_req),
    .wide_q   (wide_q),
    .mask_out (mask_out)
);

// File: tb/test_vgather_seq.sv
`timescale 1ns/1ps
module test_vgather_seq;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wide = 1'b0;
    logic [1:0]    scale_sh = '0;
    logic [63:0]   base = '0;
    logic [511:0]  idx_vec = '0;
    logic [15:0]   mask_in = '0;
    logic [511:0]  dest_in = '0;
    logic          busy, done, flt, mem_req;
    logic [511:0]  dest_out;
    logic [15:0]   mask_out;
    logic [3:0]    flt_lane;
    logic [63:0]   mem_addr;
    logic          mem_rsp = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          mem_fault = 1'b0;

    always #2 clk = ~clk;

    vgather_seq i_vgather_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .scale_sh(scale_sh),
        .base(base), .idx_vec(idx_vec), .mask_in(mask_in), .dest_in(dest_in),
        .busy(busy), .done(done), .dest_out(dest_out), .mask_out(mask_out),
        .flt(flt), .flt_lane(flt_lane), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp(mem_rsp), .mem_rdata(mem_rdata), .mem_fault(mem_fault)
    );

    int n_chk = 0;
    int n_err = 0;

    // Model of the operation under way.
    logic          m_wide;
    logic [1:0]    m_scale;
    logic [63:0]   m_base;
    logic [31:0]   m_idx [16];
    logic [15:0]   m_mask;
    logic [511:0]  m_dest;
    int            m_flt_lane;      // -1: no fault injected
    logic [15:0]   rm;              // responder's copy of pending lanes

    logic [511:0]  e_dest;
    logic [15:0]   e_mask;
    logic          e_flt;
    logic [3:0]    e_lane;

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] f_addr(input int ln);
        return m_base + ({{32{m_idx[ln][31]}}, m_idx[ln]} << m_scale);
    endfunction

    function automatic logic [63:0] f_data(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A3C_96E1, a[63:32] + a[31:0] + 32'h1357_9BDF};
    endfunction

    function automatic logic [15:0] f_eff_mask(input logic w, input logic [15:0] m);
        return w ? (m & 16'h00FF) : m;
    endfunction

    task automatic model();
        logic [15:0] m;
        m      = f_eff_mask(m_wide, m_mask);
        e_dest = m_dest;
        e_flt  = 1'b0;
        e_lane = '0;
        for (int i = 0; i < 16; i++) begin
            if (m[i] && !e_flt) begin
                if (i == m_flt_lane) begin
                    e_flt  = 1'b1;
                    e_lane = 4'(i);
                end else begin
                    if (m_wide) e_dest[64*i +: 64] = f_data(f_addr(i));
                    else        e_dest[32*i +: 32] = f_data(f_addr(i))[31:0];
                    m[i] = 1'b0;
                end
            end
        end
        e_mask = m;
    endtask

    // Memory responder: checks order and address, answers after 1..3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                int ln;
                int d;
                ln = -1;
                for (int i = 15; i >= 0; i--) if (rm[i]) ln = i;
                chk("R5 request for a pending lane", (ln >= 0), 1'b1);
                if (ln >= 0) begin
                    chk("R2 address", mem_addr, f_addr(ln));
                    rm[ln] = 1'b0;
                end
                d = $urandom_range(0, 2);
                for (int k = 0; k <= d; k++) begin
                    @(negedge clk);
                    if (mem_req) chk("R5 request while outstanding", mem_req, 1'b0);
                end
                mem_rsp   = 1'b1;
                mem_rdata = f_data(mem_addr);
                mem_fault = (ln == m_flt_lane);
                @(negedge clk);
                mem_rsp   = 1'b0;
                mem_fault = 1'b0;
            end
        end
    end

    task automatic run_op(input string tag, input bit poke_busy);
        int cnt;
        model();
        rm = f_eff_mask(m_wide, m_mask);
        @(negedge clk);
        wide     = m_wide;
        scale_sh = m_scale;
        base     = m_base;
        for (int i = 0; i < 16; i++) idx_vec[32*i +: 32] = m_idx[i];
        mask_in  = m_mask;
        dest_in  = m_dest;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({"R10 busy after start ", tag}, busy, 1'b1);
        if (poke_busy) begin
            // R9: a second launch with other operands while busy
            wide     = ~m_wide;
            scale_sh = ~m_scale;
            base     = ~m_base;
            mask_in  = ~m_mask;
            dest_in  = ~m_dest;
            idx_vec  = ~idx_vec;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        chk({"R10 done seen ", tag}, done, 1'b1);
        chk({"R3 R6 dest ", tag}, dest_out, e_dest);
        chk({"R4 R6 mask ", tag}, mask_out, e_mask);
        chk({"R6 fault flag ", tag}, flt, e_flt);
        chk({"R6 fault lane ", tag}, flt_lane, e_lane);
        if (m_wide) chk({"R1 R7 upper mask ", tag}, mask_out[15:8], 8'h00);
        @(negedge clk);
        chk({"R10 done single cycle ", tag}, done, 1'b0);
        if (e_flt) begin
            repeat (3) @(negedge clk);
            chk({"R6 fault held ", tag}, {flt, flt_lane}, {1'b1, e_lane});
        end
    endtask

    task automatic rand_operands();
        m_wide  = 1'($urandom_range(0, 1));
        m_scale = 2'($urandom_range(0, 3));
        m_base  = {$urandom(), $urandom()};
        for (int i = 0; i < 16; i++) m_idx[i] = $urandom();
        m_mask  = 16'($urandom());
        m_dest  = '0;
        for (int i = 0; i < 16; i++) m_dest[32*i +: 32] = $urandom();
        m_flt_lane = -1;
    endtask

    initial begin
        void'($urandom(32'h1D5E_A7C3));
        m_flt_lane = -1;
        rm = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset flags", {busy, done, flt, mem_req}, 4'b0000);
        chk("R11 reset dest", dest_out, '0);
        chk("R11 reset mask", mask_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4: all lanes, 32-bit
        rand_operands(); m_wide = 1'b0; m_mask = 16'hFFFF;
        run_op("R1 narrow full", 1'b0);
        // R1 R4: all lanes, 64-bit, upper mask bits set on input
        rand_operands(); m_wide = 1'b1; m_mask = 16'hFFFF;
        run_op("R1 wide full", 1'b0);
        // R3: empty mask, nothing read, destination unchanged
        rand_operands(); m_mask = 16'h0000;
        run_op("R3 empty mask", 1'b0);
        // R3: sparse mask merges
        rand_operands(); m_wide = 1'b0; m_mask = 16'h8421;
        run_op("R3 sparse", 1'b0);
        // R7: 64-bit mode, first lane faults
        rand_operands(); m_wide = 1'b1; m_mask = 16'hFF0F; m_flt_lane = 0;
        run_op("R7 wide first fault", 1'b0);
        // R6: fault on the top lane of the 32-bit mode
        rand_operands(); m_wide = 1'b0; m_mask = 16'hFFFF; m_flt_lane = 15;
        run_op("R6 last lane fault", 1'b0);
        // R6: fault mid-vector, then resume with the partial state
        rand_operands(); m_wide = 1'b0; m_mask = 16'hF0F6; m_flt_lane = 5;
        run_op("R6 mid fault", 1'b0);
        m_mask = e_mask; m_dest = e_dest; m_flt_lane = -1;
        run_op("R6 resume", 1'b0);
        // R8: odd addresses with scale 1
        rand_operands(); m_scale = 2'd0; m_base = 64'h0000_0000_0000_1001;
        for (int i = 0; i < 16; i++) m_idx[i] = 32'(2 * i + 1);
        m_mask = 16'hFFFF;
        run_op("R8 misaligned", 1'b0);
        // R2: wraparound with negative indices and scale 8
        rand_operands(); m_scale = 2'd3; m_base = 64'h0000_0000_0000_0010;
        for (int i = 0; i < 16; i++) m_idx[i] = 32'hFFFF_FF00 + 32'(i);
        m_mask = 16'hFFFF;
        run_op("R2 wrap", 1'b0);
        // R9: start while busy is ignored
        rand_operands(); m_mask = 16'h3C3C; m_wide = 1'b0;
        run_op("R9 start ignored", 1'b1);

        // Random mix
        for (int t = 0; t < 40; t++) begin
            rand_operands();
            if ($urandom_range(0, 2) == 0) m_flt_lane = $urandom_range(0, 15);
            run_op("random", (t % 5) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R10 act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule